// File: doc/BRIEF.md
# May-Be-Operation and Ordered-Access Decoder

This block is one decode stage of a 32-bit RISC-V pipeline. It accepts an instruction word, with a flag that says whether only the low 16 bits hold a compressed instruction. It sorts the word into a small set of operation classes:

- the two 32-bit may-be-operations in the SYSTEM opcode (one-source and two-source), each of which writes zero to its destination;
- the three compressed instructions that share the quadrant-1, funct3 = 3 slot: the stack-pointer adjust, load-upper-immediate and the compressed may-be-operation;
- the load-acquire and store-release accesses in the AMO opcode.

The ordered accesses come out as the ordinary load and store micro-op classes of matching width, with zero offset. Any word outside these patterns is flagged illegal.

The result is held in one output register behind a valid/ready handshake. Rules for back-pressure:

- An input is taken on a rising edge when `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, every output holds its value.
- With `out_ready` held high, the stage takes one instruction per cycle. The result of each appears in the cycle after it is taken.

Top module: `mop_order_decode`

## Requirements
- R1: The stage takes an input when `in_valid && in_ready`, and shows its result with `out_valid` high from the next rising edge. `in_ready` equals `!out_valid || out_ready`. Outputs stay stable while `out_valid && !out_ready`.
- R2: A synchronous reset (`rst` high at a rising edge) clears `out_valid`, so `in_ready` reads 1 afterwards.
- R3: A 32-bit word with opcode [6:0] = 1110011, funct3 [14:12] = 4, bits 31, 24, 23 and 22 set and bits 29, 28 and 25 clear decodes as follows:
  - class bit 0 (one-source may-be-operation), with `out_zero_rd` = 1;
  - rd = [11:7], rs1 = [19:15], rs2 = 0;
  - `out_imm` = the index {b30, b27, b26, b21, b20}.
- R4: The same opcode and funct3, with bits 31 and 25 set and bits 29 and 28 clear, decodes as follows:
  - class bit 1 (two-source may-be-operation), with `out_zero_rd` = 1;
  - rd = [11:7], rs1 = [19:15], rs2 = [24:20];
  - `out_imm` = {b30, b27, b26}.
- R5: For a compressed word (bits [1:0] = 01, funct3 [15:13] = 3) with rd field [11:7] = 2, the result is class bit 3 (stack-pointer adjust), with rd = rs1 = 2. `out_imm` is the sign-extended value whose bits are: 9 = b12, 8:7 = b4:3, 6 = b5, 5 = b2, 4 = b6, and 3:0 = 0.
- R6: In that slot, an rd field other than 2 with a non-zero 6-bit immediate {b12, b6:b2} gives class bit 4 (load-upper-immediate). rd = [11:7], rs1 = rs2 = 0, and `out_imm` = the sign-extended 6-bit immediate shifted left by 12.
- R7: In that slot, a zero immediate with an odd rd field no greater than 15 gives class bit 2 (compressed may-be-operation). This class has no architectural effect: rd = rs1 = rs2 = 0, `out_zero_rd` = 0, and `out_imm` = rd field >> 1.
- R8: A 32-bit word with opcode 0101111, funct5 [31:27] = 6, rs2 [24:20] = 0 and funct3 of 0, 1 or 2 gives class bit 5 (plain signed load). `out_width` = funct3 (0 byte, 1 half, 2 word), rd = [11:7], rs1 = [19:15], rs2 = 0 and `out_imm` = 0. Bits 26:25 are ignored.
- R9: In the same opcode, funct5 = 7 with rd [11:7] = 0 and funct3 of 0, 1 or 2 gives class bit 6 (plain store). `out_width` = funct3, rs1 = [19:15], rs2 = [24:20], rd = 0 and `out_imm` = 0. Bits 26:25 are ignored.
- R10: Every other word gives class = 0 and `out_illegal` = 1, with all index, width, immediate and zero-rd outputs at 0. This includes compressed words outside the slot and AMO-opcode words with funct3 above 2.
- R11: With `in_compressed` high, bits [31:16] of `in_insn` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Stage can take an instruction |
| in_insn | input | 32 | Instruction word |
| in_compressed | input | 1 | Low 16 bits hold a compressed instruction |
| out_valid | output | 1 | Decode result present |
| out_ready | input | 1 | Consumer takes the result |
| out_class | output | 7 | One-hot operation class (bit positions as in R3 to R9) |
| out_illegal | output | 1 | No recognised pattern |
| out_zero_rd | output | 1 | Write zero to rd |
| out_rd | output | 5 | Destination index |
| out_rs1 | output | 5 | First source index |
| out_rs2 | output | 5 | Second source index |
| out_width | output | 2 | Access width for load/store classes |
| out_imm | output | 32 | Immediate or may-be-operation index |

## Verification
The assertions take for granted that `out_ready` is a plain level input and that `in_valid` may be dropped or changed freely. The handshake property therefore constrains only the output side. They also assume `rst` is held for at least one edge before the first transfer. The bench drives every input at the falling edge and starts with two reset cycles. The field-coupling properties rely on the decoders seeing only defined input values, so the bench never drives X onto `in_insn`.

// File: rtl/mobd_pkg.sv
package mobd_pkg;
  localparam int ILEN = 32;
  localparam int CLEN = 16;
  localparam int REGW = 5;
  localparam int NCLS = 7;
  localparam int WIDW = 2;

  localparam int CLS_MOP_R   = 0;
  localparam int CLS_MOP_RR  = 1;
  localparam int CLS_CMOP    = 2;
  localparam int CLS_SPADJ   = 3;
  localparam int CLS_LUI     = 4;
  localparam int CLS_LOAD    = 5;
  localparam int CLS_STORE   = 6;

  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [6:0] OPC_AMO    = 7'b0101111;
  localparam logic [2:0] F3_MOP     = 3'd4;
  localparam logic [4:0] F5_LDACQ   = 5'd6;
  localparam logic [4:0] F5_STREL   = 5'd7;
  localparam logic [1:0] CQ_ONE     = 2'b01;
  localparam logic [2:0] CF3_LUI    = 3'd3;
  localparam logic [REGW-1:0] SP_IDX = 5'd2;

  typedef struct packed {
    logic [NCLS-1:0] cls;
    logic            illegal;
    logic            zero_rd;
    logic [REGW-1:0] rd;
    logic [REGW-1:0] rs1;
    logic [REGW-1:0] rs2;
    logic [WIDW-1:0] width;
    logic [ILEN-1:0] imm;
  } dec_t;

  localparam int DEC_W = $bits(dec_t);
endpackage

// File: rtl/mobd_wide_dec.sv
module mobd_wide_dec
  import mobd_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  output dec_t            dec
);
  logic [6:0]      opc;
  logic [2:0]      f3;
  logic [4:0]      f5;
  logic [REGW-1:0] f_rd, f_rs1, f_rs2;
  logic            mop_r_hit, mop_rr_hit, ld_hit, st_hit, width_ok;

  assign opc   = insn[6:0];
  assign f3    = insn[14:12];
  assign f5    = insn[31:27];
  assign f_rd  = insn[11:7];
  assign f_rs1 = insn[19:15];
  assign f_rs2 = insn[24:20];

  assign mop_r_hit  = (opc == OPC_SYSTEM) && (f3 == F3_MOP) &&
                      insn[31] && insn[24] && insn[23] && insn[22] &&
                      !insn[29] && !insn[28] && !insn[25];
  assign mop_rr_hit = (opc == OPC_SYSTEM) && (f3 == F3_MOP) &&
                      insn[31] && insn[25] && !insn[29] && !insn[28];
  assign width_ok   = (f3 <= 3'd2);
  assign ld_hit     = (opc == OPC_AMO) && width_ok && (f5 == F5_LDACQ) && (f_rs2 == '0);
  assign st_hit     = (opc == OPC_AMO) && width_ok && (f5 == F5_STREL) && (f_rd == '0);

  always_comb begin
    dec         = '0;
    dec.illegal = 1'b1;
    if (mop_r_hit) begin
      dec.cls[CLS_MOP_R] = 1'b1;
      dec.illegal = 1'b0;
      dec.zero_rd = 1'b1;
      dec.rd      = f_rd;
      dec.rs1     = f_rs1;
      dec.imm     = {{(ILEN-5){1'b0}}, insn[30], insn[27], insn[26], insn[21], insn[20]};
    end else if (mop_rr_hit) begin
      dec.cls[CLS_MOP_RR] = 1'b1;
      dec.illegal = 1'b0;
      dec.zero_rd = 1'b1;
      dec.rd      = f_rd;
      dec.rs1     = f_rs1;
      dec.rs2     = f_rs2;
      dec.imm     = {{(ILEN-3){1'b0}}, insn[30], insn[27], insn[26]};
    end else if (ld_hit) begin
      dec.cls[CLS_LOAD] = 1'b1;
      dec.illegal = 1'b0;
      dec.rd      = f_rd;
      dec.rs1     = f_rs1;
      dec.width   = f3[WIDW-1:0];
    end else if (st_hit) begin
      dec.cls[CLS_STORE] = 1'b1;
      dec.illegal = 1'b0;
      dec.rs1     = f_rs1;
      dec.rs2     = f_rs2;
      dec.width   = f3[WIDW-1:0];
    end
  end
endmodule

// File: rtl/mobd_compact_dec.sv
module mobd_compact_dec
  import mobd_pkg::*;
(
  input  logic [CLEN-1:0] half,
  output dec_t            dec
);
  logic            in_slot, imm_nz, rd_is_sp, rd_cmop;
  logic [REGW-1:0] f_rd;
  logic [5:0]      imm6;

  assign f_rd     = half[11:7];
  assign imm6     = {half[12], half[6:2]};
  assign in_slot  = (half[1:0] == CQ_ONE) && (half[15:13] == CF3_LUI);
  assign imm_nz   = (imm6 != '0);
  assign rd_is_sp = (f_rd == SP_IDX);
  assign rd_cmop  = f_rd[0] && !f_rd[4];

  always_comb begin
    dec         = '0;
    dec.illegal = 1'b1;
    if (in_slot) begin
      if (rd_is_sp) begin
        dec.cls[CLS_SPADJ] = 1'b1;
        dec.illegal = 1'b0;
        dec.rd      = SP_IDX;
        dec.rs1     = SP_IDX;
        dec.imm     = {{(ILEN-10){half[12]}}, half[12], half[4:3], half[5],
                       half[2], half[6], 4'b0000};
      end else if (imm_nz) begin
        dec.cls[CLS_LUI] = 1'b1;
        dec.illegal = 1'b0;
        dec.rd      = f_rd;
        dec.imm     = {{(ILEN-18){half[12]}}, imm6, 12'h000};
      end else if (rd_cmop) begin
        dec.cls[CLS_CMOP] = 1'b1;
        dec.illegal = 1'b0;
        dec.imm     = {{(ILEN-3){1'b0}}, f_rd[3:1]};
      end
    end
  end
endmodule

// File: rtl/mobd_out_stage.sv
module mobd_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/mop_order_decode.sv
module mop_order_decode
  import mobd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [ILEN-1:0] in_insn,
  input  logic            in_compressed,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [NCLS-1:0] out_class,
  output logic            out_illegal,
  output logic            out_zero_rd,
  output logic [REGW-1:0] out_rd,
  output logic [REGW-1:0] out_rs1,
  output logic [REGW-1:0] out_rs2,
  output logic [WIDW-1:0] out_width,
  output logic [ILEN-1:0] out_imm
);
  dec_t             wide_res, comp_res, sel_res, held;
  logic [DEC_W-1:0] held_bits;

  mobd_wide_dec u_wide (
    .insn (in_insn),
    .dec  (wide_res)
  );

  mobd_compact_dec u_compact (
    .half (in_insn[CLEN-1:0]),
    .dec  (comp_res)
  );

  assign sel_res = in_compressed ? comp_res : wide_res;

  mobd_out_stage #(.W(DEC_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (sel_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held_bits)
  );

  assign held        = dec_t'(held_bits);
  assign out_class   = held.cls;
  assign out_illegal = held.illegal;
  assign out_zero_rd = held.zero_rd;
  assign out_rd      = held.rd;
  assign out_rs1     = held.rs1;
  assign out_rs2     = held.rs2;
  assign out_width   = held.width;
  assign out_imm     = held.imm;
endmodule

// File: rtl/mop_order_decode_chk.sv
module mop_order_decode_chk
  import mobd_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [NCLS-1:0] out_class,
  input logic            out_illegal,
  input logic            out_zero_rd,
  input logic [REGW-1:0] out_rd,
  input logic [REGW-1:0] out_rs2,
  input logic [WIDW-1:0] out_width,
  input logic [ILEN-1:0] out_imm
);
  // R1: stalled output holds
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_class) &&
                                   $stable(out_imm) && $stable(out_rd)));

  // R1: ready relation
  p_ready_r1: assert property (@(posedge clk) disable iff (rst)
    (!out_valid) |-> in_ready);

  // R2: reset empties the stage
  p_reset_r2: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R10: class is one-hot unless illegal
  p_class_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($onehot0(out_class) && (out_illegal == (out_class == '0))));

  // R3/R4: zero-write only for the 32-bit may-be-operations
  p_zero_rd_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_zero_rd) |-> (out_class[CLS_MOP_R] || out_class[CLS_MOP_RR]));

  // R7: compressed may-be-operation has no effect
  p_cmop_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class[CLS_CMOP]) |-> (!out_zero_rd && out_rd == '0 && out_imm < 8));

  // R9: store-release writes no register and has no offset
  p_store_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class[CLS_STORE]) |-> (out_rd == '0 && out_imm == '0 && out_width != 2'd3));

  // R8: load-acquire has no second source
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class[CLS_LOAD]) |-> (out_rs2 == '0 && out_imm == '0 && out_width != 2'd3));
endmodule

bind mop_order_decode mop_order_decode_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_class   (out_class),
  .out_illegal (out_illegal),
  .out_zero_rd (out_zero_rd),
  .out_rd      (out_rd),
  .out_rs2     (out_rs2),
  .out_width   (out_width),
  .out_imm     (out_imm)
);

// File: tb/tb_mop_order_decode.sv
module tb_mop_order_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic        in_compressed = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [6:0]  out_class;
  logic        out_illegal, out_zero_rd;
  logic [4:0]  out_rd, out_rs1, out_rs2;
  logic [1:0]  out_width;
  logic [31:0] out_imm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mop_order_decode dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_compressed(in_compressed),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
    .out_illegal(out_illegal), .out_zero_rd(out_zero_rd), .out_rd(out_rd),
    .out_rs1(out_rs1), .out_rs2(out_rs2), .out_width(out_width), .out_imm(out_imm)
  );

  // expected bundle: class, illegal, zero_rd, rd, rs1, rs2, width, imm
  function automatic logic [57:0] model(input logic [31:0] w, input logic c);
    logic [6:0] k = '0; logic il = 1'b0, zr = 1'b0;
    logic [4:0] rd = '0, r1 = '0, r2 = '0; logic [1:0] wd = '0;
    int v = 0; int f3, f5, op, rdf, i6;
    if (c) begin
      rdf = int'(w[11:7]);
      i6  = int'({w[12], w[6:2]});
      if (w[1:0] == 2'b01 && w[15:13] == 3'd3) begin
        if (rdf == 2) begin
          k = 7'd8; rd = 5'd2; r1 = 5'd2;
          v = 16*w[6] + 32*w[2] + 64*w[5] + 128*w[3] + 256*w[4];
          if (w[12]) v = v - 512;
        end else if (i6 != 0) begin
          k = 7'd16; rd = w[11:7];
          v = (i6 >= 32) ? (i6 - 64) * 4096 : i6 * 4096;
        end else if ((rdf % 2) == 1 && rdf <= 15) begin
          k = 7'd4; v = rdf / 2;
        end else il = 1'b1;
      end else il = 1'b1;
    end else begin
      op = int'(w[6:0]); f3 = int'(w[14:12]); f5 = int'(w[31:27]);
      if (op == 'h73 && f3 == 4 && w[31] && w[24] && w[23] && w[22] &&
          !w[29] && !w[28] && !w[25]) begin
        k = 7'd1; zr = 1'b1; rd = w[11:7]; r1 = w[19:15];
        v = 16*w[30] + 8*w[27] + 4*w[26] + 2*w[21] + w[20];
      end else if (op == 'h73 && f3 == 4 && w[31] && w[25] && !w[29] && !w[28]) begin
        k = 7'd2; zr = 1'b1; rd = w[11:7]; r1 = w[19:15]; r2 = w[24:20];
        v = 4*w[30] + 2*w[27] + w[26];
      end else if (op == 'h2F && f3 <= 2 && f5 == 6 && w[24:20] == 0) begin
        k = 7'd32; rd = w[11:7]; r1 = w[19:15]; wd = 2'(f3);
      end else if (op == 'h2F && f3 <= 2 && f5 == 7 && w[11:7] == 0) begin
        k = 7'd64; r1 = w[19:15]; r2 = w[24:20]; wd = 2'(f3);
      end else il = 1'b1;
    end
    return {k, il, zr, rd, r1, r2, wd, 32'(v)};
  endfunction

  function automatic string tag_of(input logic [57:0] e, input bit upper_rand);
    if (upper_rand && e[57:51] != 0) return "R11";
    case (e[57:51])
      7'd1:  return "R3";
      7'd2:  return "R4";
      7'd4:  return "R7";
      7'd8:  return "R5";
      7'd16: return "R6";
      7'd32: return "R8";
      7'd64: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [57:0] actual();
    return {out_class, out_illegal, out_zero_rd, out_rd, out_rs1, out_rs2, out_width, out_imm};
  endfunction

  task automatic check_eq(input string tag, input logic [57:0] act, input logic [57:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] w, input logic c, input bit upper_rand);
    logic [57:0] e;
    e = model(w, c);
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_compressed = c; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (!out_valid) begin
      checks++; fails++;
      $display("FAIL R1 actual out_valid=0 expected=1");
    end else check_eq(tag_of(e, upper_rand), actual(), e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [57:0] prev, a_exp, b_exp;
    // R2: reset state, input ignored during reset
    in_valid = 1'b1; in_insn = 32'h0000_002F;
    repeat (2) @(negedge clk);
    check_bit("R2", out_valid, 1'b0);
    check_bit("R2", in_ready, 1'b1);
    rst = 1'b0; in_valid = 1'b0;

    // R5 R6 R7 R11: full sweep of the shared compressed slot, random upper half
    for (int i = 0; i < 2048; i++) begin
      w = {$urandom() % 65536, 3'b011, 11'(i), 2'b01};
      w[31:16] = 16'($urandom());
      run_one(w, 1'b1, 1'b1);
    end
    // R10: compressed words outside the slot
    for (int q = 0; q < 4; q++)
      for (int f = 0; f < 8; f++)
        if (!(q == 1 && f == 3)) run_one({16'h0, 3'(f), 11'($urandom()), 2'(q)}, 1'b1, 1'b0);

    // R3 R4 R10: SYSTEM funct3=4 over every pattern of bits 31:20
    for (int i = 0; i < 4096; i++)
      run_one({12'(i), 5'((i * 7) % 32), 3'd4, 5'(i % 32), 7'h73}, 1'b0, 1'b0);

    // R8 R9 R10: AMO opcode over funct5, funct3, ordering bits, rs2/rd zero or not
    for (int f5 = 0; f5 < 32; f5++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int ar = 0; ar < 4; ar++)
          for (int z = 0; z < 4; z++)
            run_one({5'(f5), 2'(ar), (z[0] ? 5'd0 : 5'd5), 5'd11, 3'(f3),
                     (z[1] ? 5'd0 : 5'd9), 7'h2F}, 1'b0, 1'b0);

    // R10: other opcodes and random words
    for (int i = 0; i < 256; i++) run_one($urandom(), 1'b0, 1'b0);

    // R1: back-to-back, one per cycle
    @(negedge clk);
    out_ready = 1'b1;
    for (int k = 0; k < 9; k++) begin
      if (k > 0) begin
        check_bit("R1", out_valid, 1'b1);
        check_eq("R1", actual(), prev);
      end
      if (k < 8) begin
        w = {5'd6, 2'b11, 5'd0, 5'(k + 3), 3'(k % 3), 5'(k + 1), 7'h2F};
        in_valid = 1'b1; in_insn = w; in_compressed = 1'b0;
        prev = model(w, 1'b0);
      end else in_valid = 1'b0;
      @(negedge clk);
    end
    check_bit("R1", out_valid, 1'b0);

    // R1: back-pressure holds result and blocks input
    w = 32'hC1C4_C073;
    a_exp = model(w, 1'b0);
    out_ready = 1'b0; in_valid = 1'b1; in_insn = w;
    @(negedge clk);
    check_bit("R1", in_ready, 1'b0);
    in_insn = {16'h0, 16'h6085}; in_compressed = 1'b1;
    b_exp = model(in_insn, 1'b1);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check_eq("R1", actual(), a_exp);
      check_bit("R1", out_valid, 1'b1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check_eq("R1", actual(), b_exp);
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R1", out_valid, 1'b0);

    // R2: reset while a result is held
    out_ready = 1'b0; in_valid = 1'b1; in_compressed = 1'b0; in_insn = 32'h0000_0013;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check_bit("R2", out_valid, 1'b0);
    check_bit("R2", in_ready, 1'b1);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule